// File: doc/BRIEF.md
# USB Host Controller Command Register Unit

This unit is the run-control register of a USB 2.0 host controller. Software reaches it through a simple word-wide bus port at a fixed offset. It holds the controls that start and stop the controller, reset it, ring the async-advance doorbell, enable the periodic and asynchronous schedules, and set the interrupt rate, frame list size and async park behaviour. Each control is driven as a level to the controller core.

Some bits are requests that the core completes. The full reset, the light reset and the doorbell stay at 1 until the core returns a one-cycle completion strobe. The bits then clear themselves. When the full reset completes, the whole register goes back to its power-up image.

The unit also owns the halted flag. It drops one cycle after run is accepted. Once run is cleared, it rises when the core reports an idle pipeline, or on the sixteenth microframe tick, whichever comes first. Writes that would start or reset a controller that is not halted are dropped, so the core never sees those requests.

Top module: `hc_cmd_reg`

## Requirements
- R1: After reset, a read at offset 0x10 returns 0x00080B00. In that image the interrupt rate field (bits 23:16) is 8, the park enable (bit 11) is 1 and the park count (bits 9:8) is 3. After reset, halted is 1 and every request output is 0.
- R2: A write of 1 to bit 0 (run) is accepted only while halted is 1 and no full reset is pending. Halted then goes to 0 on the clock edge after the write edge. A write of 1 to run while halted is 0 leaves run at 0. A write of 0 to run always clears it.
- R3: While run is 0 and halted is 0, a one-cycle pipeline-idle pulse makes halted 1 on that clock edge.
- R4: While run is 0 and halted is 0 with no idle pulse, halted stays 0 through 15 microframe ticks and becomes 1 on the 16th tick.
- R5: A write of 1 to bit 1 (full reset) while halted is 1 sets the bit and the reset request. Writing 0 to the bit does not clear it. A reset-done strobe clears it and restores the whole register to 0x00080B00.
- R6: A write of 1 to bit 1 while halted is 0 is ignored. The bit reads 0 and the reset request stays low.
- R7: A write of 1 to bit 6 (doorbell) sets it and the doorbell request. A write of 0 leaves it set. An advance-done strobe clears it.
- R8: A write of 1 to bit 7 (light reset) sets it. A write of 0 leaves it set, and a light-done strobe clears it. When the light reset is configured out, bit 7 always reads 0.
- R9: Bits 3:2 (frame list size) change only when the programmable-list capability input is 1. Code 0 selects 1024 entries, 1 selects 512 and 2 selects 256. A write of code 3 (reserved) leaves the field unchanged.
- R10: Bits 23:16 (interrupt rate) accept only 1, 2, 4, 8, 16, 32 or 64. Any other written value leaves the field unchanged.
- R11: Bit 4 (periodic enable) and bit 5 (async enable) are plain read/write bits and drive their schedule-enable outputs directly.
- R12: Bit 11 (park enable) and bits 9:8 (park count) change only when the park capability input is 1.
- R13: A read at any other offset returns 0. A write at any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_prog_flist | input | 1 | Frame list size is programmable |
| cap_park | input | 1 | Async park controls are writable |
| uframe_tick | input | 1 | One-cycle pulse per 125 us microframe |
| core_pipe_idle | input | 1 | Core has drained its pipelined work |
| core_reset_done | input | 1 | Core finished the full reset |
| core_light_done | input | 1 | Core finished the light reset |
| core_iaa_done | input | 1 | Core set the async-advance status flag |
| run_req | output | 1 | Run the schedules |
| reset_req | output | 1 | Full reset in progress |
| light_reset_req | output | 1 | Light reset in progress |
| doorbell_req | output | 1 | Async-advance doorbell pending |
| per_sched_en | output | 1 | Periodic schedule enable |
| async_sched_en | output | 1 | Asynchronous schedule enable |
| flist_size | output | 2 | Frame list size code |
| irq_thresh | output | 8 | Interrupt rate in microframes |
| park_en | output | 1 | Async park mode enable |
| park_cnt | output | 2 | Async park transaction count |
| halted | output | 1 | Controller is halted |

## Verification
The plain fields are exercised by a sequence of writes that mixes legal values with refused ones. These include invalid interrupt rates, the reserved list-size code, and writes made with each capability input low. Each result then shows whether the write landed or was dropped for the right reason. The halt logic is driven along two exits from the stopping state, an idle pulse and a run of microframe ticks. Counting ticks separates a premature halt at the fifteenth tick from a late one. Each request bit is given a write of 0 before its completion strobe, which tells a true completion-driven clear from one that follows software. Run and reset writes are also made while the controller is not halted, which shows that the guard refuses them.

// File: rtl/hc_cmd_pkg.sv
// Shared constants and types for the host controller command register.
// Assumes a 32-bit register; field positions are fixed by software view.
package hc_cmd_pkg;

    localparam int unsigned REG_W = 32;

    // bit positions of the controls
    localparam int unsigned B_RUN    = 0;
    localparam int unsigned B_RESET  = 1;
    localparam int unsigned B_FLS_LO = 2;
    localparam int unsigned B_PSE    = 4;
    localparam int unsigned B_ASE    = 5;
    localparam int unsigned B_BELL   = 6;
    localparam int unsigned B_LIGHT  = 7;
    localparam int unsigned B_PCNT_LO = 8;
    localparam int unsigned B_PEN    = 11;
    localparam int unsigned B_ITC_LO = 16;

    localparam int unsigned ITC_W  = 8;
    localparam int unsigned ITC_MAX = 64;

    typedef enum logic [1:0] {
        FLS_1024 = 2'd0,
        FLS_512  = 2'd1,
        FLS_256  = 2'd2,
        FLS_RSVD = 2'd3
    } fls_e;

    localparam logic [ITC_W-1:0] ITC_RST  = 8'd8;
    localparam logic             PEN_RST  = 1'b1;
    localparam logic [1:0]       PCNT_RST = 2'd3;

    // interrupt rate code is legal when it is a power of two up to ITC_MAX
    function automatic logic itc_legal(input logic [ITC_W-1:0] v);
        return (v != '0) && ((v & (v - 8'd1)) == '0) && (int'(v) <= ITC_MAX);
    endfunction

endpackage

// File: rtl/hc_req_bit.sv
// Request bit set by a software write of 1 and cleared only by a core
// completion strobe or a block-wide soft reset. Writes of 0 are ignored.
// Assumes completion strobes are one cycle wide.
module hc_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic set_req,
    input  logic done,
    output logic q
);

    // hold the request until the core reports completion
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            q <= 1'b0;
        end else if (q) begin
            if (done) begin
                q <= 1'b0;
            end
        end else if (set_req) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/hc_halt_tracker.sv
// Halted flag and stop deadline. Halted falls the cycle after run is seen
// while halted; once run is cleared it rises on pipeline idle or on the
// HALT_UFRAMES-th microframe tick, whichever comes first.
// Assumes uframe_tick is a one-cycle pulse.
module hc_halt_tracker #(
    parameter int unsigned HALT_UFRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic run,
    input  logic pipe_idle,
    input  logic tick,
    output logic halted
);

    localparam int unsigned CNT_W = $clog2(HALT_UFRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_UFRAMES - 1);

    logic [CNT_W-1:0] tick_cnt;

    // halted state and microframe count while stopping
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            halted   <= 1'b1;
            tick_cnt <= '0;
        end else if (halted) begin
            tick_cnt <= '0;
            if (run) begin
                halted <= 1'b0;
            end
        end else if (run) begin
            tick_cnt <= '0;
        end else if (pipe_idle) begin
            halted   <= 1'b1;
            tick_cnt <= '0;
        end else if (tick) begin
            if (tick_cnt == CNT_LAST) begin
                halted   <= 1'b1;
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hc_cmd_fields.sv
// Plain configuration fields: interrupt rate, frame list size, schedule
// enables and async park controls, with their write-acceptance rules.
// Assumes wr_hit is already decoded for this register.
module hc_cmd_fields
    import hc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_hit,
    input  logic [ITC_W-1:0] wr_itc,
    input  logic [1:0]       wr_fls,
    input  logic             wr_pse,
    input  logic             wr_ase,
    input  logic             wr_pen,
    input  logic [1:0]       wr_pcnt,
    input  logic             cap_prog_flist,
    input  logic             cap_park,
    output logic [ITC_W-1:0] itc,
    output logic [1:0]       fls,
    output logic             pse,
    output logic             ase,
    output logic             pen,
    output logic [1:0]       pcnt
);

    // interrupt rate: only legal codes are taken
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            itc <= ITC_RST;
        end else if (wr_hit && itc_legal(wr_itc)) begin
            itc <= wr_itc;
        end
    end

    // frame list size: programmable only with capability, reserved code refused
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            fls <= FLS_1024;
        end else if (wr_hit && cap_prog_flist && (wr_fls != FLS_RSVD)) begin
            fls <= wr_fls;
        end
    end

    // schedule enables: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            pse <= 1'b0;
            ase <= 1'b0;
        end else if (wr_hit) begin
            pse <= wr_pse;
            ase <= wr_ase;
        end
    end

    // park controls: writable only with park capability
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            pen  <= PEN_RST;
            pcnt <= PCNT_RST;
        end else if (wr_hit && cap_park) begin
            pen  <= wr_pen;
            pcnt <= wr_pcnt;
        end
    end

endmodule

// File: rtl/hc_cmd_reg.sv
// Command register unit of a USB 2.0 host controller. Decodes bus writes
// at REG_OFFSET, guards run and reset against a non-halted controller,
// keeps the self-clearing request bits and the halted flag, and returns
// the register image on reads. Assumes single-cycle write strobes.
module hc_cmd_reg
    import hc_cmd_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET   = 8'h10,
    parameter int unsigned       HALT_UFRAMES = 16,
    parameter bit                LIGHT_RST_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cap_prog_flist,
    input  logic              cap_park,
    input  logic              uframe_tick,
    input  logic              core_pipe_idle,
    input  logic              core_reset_done,
    input  logic              core_light_done,
    input  logic              core_iaa_done,
    output logic              run_req,
    output logic              reset_req,
    output logic              light_reset_req,
    output logic              doorbell_req,
    output logic              per_sched_en,
    output logic              async_sched_en,
    output logic [1:0]        flist_size,
    output logic [ITC_W-1:0]  irq_thresh,
    output logic              park_en,
    output logic [1:0]        park_cnt,
    output logic              halted
);

    logic addr_hit;
    logic wr_hit;
    logic soft_clr;
    logic unused_wbits;

    // address decode shared by reads and writes
    assign addr_hit = (bus_addr == REG_OFFSET);
    assign wr_hit   = bus_wr && addr_hit;
    // completion of a full reset restores the whole register
    assign soft_clr = reset_req && core_reset_done;
    assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[15:12], bus_wdata[10]};

    // run/stop: set only from halted, cleared by any write of 0
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            run_req <= 1'b0;
        end else if (wr_hit) begin
            if (!bus_wdata[B_RUN]) begin
                run_req <= 1'b0;
            end else if (halted && !reset_req) begin
                run_req <= 1'b1;
            end
        end
    end

    hc_halt_tracker #(
        .HALT_UFRAMES(HALT_UFRAMES)
    ) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .run      (run_req),
        .pipe_idle(core_pipe_idle),
        .tick     (uframe_tick),
        .halted   (halted)
    );

    hc_req_bit u_reset_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(1'b0),
        .set_req (wr_hit && bus_wdata[B_RESET] && halted),
        .done    (core_reset_done),
        .q       (reset_req)
    );

    hc_req_bit u_bell_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_clr),
        .set_req (wr_hit && bus_wdata[B_BELL]),
        .done    (core_iaa_done),
        .q       (doorbell_req)
    );

    generate
        if (LIGHT_RST_EN) begin : g_light
            hc_req_bit u_light_bit (
                .clk     (clk),
                .rst_n   (rst_n),
                .soft_clr(soft_clr),
                .set_req (wr_hit && bus_wdata[B_LIGHT]),
                .done    (core_light_done),
                .q       (light_reset_req)
            );
        end else begin : g_no_light
            logic unused_light;
            assign unused_light    = core_light_done;
            assign light_reset_req = 1'b0;
        end
    endgenerate

    hc_cmd_fields u_fields (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_clr      (soft_clr),
        .wr_hit        (wr_hit),
        .wr_itc        (bus_wdata[B_ITC_LO +: ITC_W]),
        .wr_fls        (bus_wdata[B_FLS_LO +: 2]),
        .wr_pse        (bus_wdata[B_PSE]),
        .wr_ase        (bus_wdata[B_ASE]),
        .wr_pen        (bus_wdata[B_PEN]),
        .wr_pcnt       (bus_wdata[B_PCNT_LO +: 2]),
        .cap_prog_flist(cap_prog_flist),
        .cap_park      (cap_park),
        .itc           (irq_thresh),
        .fls           (flist_size),
        .pse           (per_sched_en),
        .ase           (async_sched_en),
        .pen           (park_en),
        .pcnt          (park_cnt)
    );

    // read image assembly
    always_comb begin
        bus_rdata = '0;
        if (addr_hit) begin
            bus_rdata[B_RUN]             = run_req;
            bus_rdata[B_RESET]           = reset_req;
            bus_rdata[B_FLS_LO +: 2]     = flist_size;
            bus_rdata[B_PSE]             = per_sched_en;
            bus_rdata[B_ASE]             = async_sched_en;
            bus_rdata[B_BELL]            = doorbell_req;
            bus_rdata[B_LIGHT]           = light_reset_req;
            bus_rdata[B_PCNT_LO +: 2]    = park_cnt;
            bus_rdata[B_PEN]             = park_en;
            bus_rdata[B_ITC_LO +: ITC_W] = irq_thresh;
        end
    end

endmodule

// File: rtl/hc_cmd_reg_chk.sv
// Checker for the command register unit, attached to every instance by bind.
// Keeps its own microframe count while stopping to bound the halt deadline.
module hc_cmd_reg_chk #(
    parameter int unsigned HALT_UFRAMES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic run_req,
    input logic reset_req,
    input logic doorbell_req,
    input logic halted,
    input logic uframe_tick,
    input logic core_pipe_idle,
    input logic core_reset_done,
    input logic core_iaa_done
);

    localparam int unsigned CW = $clog2(HALT_UFRAMES + 1) + 1;
    logic [CW-1:0] stop_ticks;

    // independent count of ticks seen while stopping
    always_ff @(posedge clk) begin
        if (!rst_n || halted || run_req) begin
            stop_ticks <= '0;
        end else if (uframe_tick) begin
            stop_ticks <= stop_ticks + 1'b1;
        end
    end

    AST_RUN_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req) |-> $past(halted)); // R2
    AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && halted) |=> !halted); // R2
    AST_IDLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req && !halted && core_pipe_idle) |=> halted); // R3
    AST_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |-> (stop_ticks < CW'(HALT_UFRAMES))); // R4
    AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !core_reset_done) |=> reset_req); // R5
    AST_RESET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && core_reset_done) |=> (halted && !run_req && !doorbell_req)); // R5
    AST_RESET_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(halted)); // R6
    AST_BELL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell_req && !core_iaa_done && !(reset_req && core_reset_done)) |=> doorbell_req); // R7

endmodule

bind hc_cmd_reg hc_cmd_reg_chk #(
    .HALT_UFRAMES(HALT_UFRAMES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_req        (run_req),
    .reset_req      (reset_req),
    .doorbell_req   (doorbell_req),
    .halted         (halted),
    .uframe_tick    (uframe_tick),
    .core_pipe_idle (core_pipe_idle),
    .core_reset_done(core_reset_done),
    .core_iaa_done  (core_iaa_done)
);

// File: tb/tb_hc_cmd_reg.sv
`timescale 1ns/1ps
module tb_hc_cmd_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_prog_flist = 1'b0;
    logic        cap_park = 1'b0;
    logic        uframe_tick = 1'b0;
    logic        core_pipe_idle = 1'b0;
    logic        core_reset_done = 1'b0;
    logic        core_light_done = 1'b0;
    logic        core_iaa_done = 1'b0;
    logic        run_req, reset_req, light_reset_req, doorbell_req;
    logic        per_sched_en, async_sched_en, park_en, halted;
    logic [1:0]  flist_size, park_cnt;
    logic [7:0]  irq_thresh;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hc_cmd_reg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_prog_flist(cap_prog_flist), .cap_park(cap_park),
        .uframe_tick(uframe_tick), .core_pipe_idle(core_pipe_idle),
        .core_reset_done(core_reset_done), .core_light_done(core_light_done),
        .core_iaa_done(core_iaa_done), .run_req(run_req), .reset_req(reset_req),
        .light_reset_req(light_reset_req), .doorbell_req(doorbell_req),
        .per_sched_en(per_sched_en), .async_sched_en(async_sched_en),
        .flist_size(flist_size), .irq_thresh(irq_thresh), .park_en(park_en),
        .park_cnt(park_cnt), .halted(halted)
    );

    typedef struct packed {
        logic [31:0] wd;
        logic        prog;
        logic        park;
        logic [31:0] exp;
    } vec_t;

    // cumulative field writes made while halted (R9, R10, R11, R12)
    localparam vec_t VECS [6] = '{
        '{32'h00040B30, 1'b0, 1'b1, 32'h00040B30},
        '{32'h00030B08, 1'b1, 1'b1, 32'h00040B08},
        '{32'h0040000C, 1'b1, 1'b0, 32'h00400B08},
        '{32'h00010104, 1'b0, 1'b1, 32'h00010108},
        '{32'h00000004, 1'b1, 1'b1, 32'h00010004},
        '{32'h00200010, 1'b0, 1'b0, 32'h00200014}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h10;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 8'h10;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h10, r); chk("R1 image", r, 32'h00080B00);
        chk("R1 halted", {31'b0, halted}, 1);
        chk("R1 requests", {28'b0, run_req, reset_req, light_reset_req, doorbell_req}, 0);

        // R13 other offsets
        rd(8'h14, r); chk("R13 read elsewhere", r, 0);
        wr(8'h14, 32'h00400034);
        rd(8'h10, r); chk("R13 write elsewhere", r, 32'h00080B00);

        // table walk
        foreach (VECS[i]) begin
            cap_prog_flist = VECS[i].prog; cap_park = VECS[i].park;
            wr(8'h10, VECS[i].wd);
            rd(8'h10, r); chk("R9/R10/R12 field write", r, VECS[i].exp);
            chk("R11 schedule outputs", {30'b0, async_sched_en, per_sched_en},
                {30'b0, VECS[i].exp[5], VECS[i].exp[4]});
        end
        cap_prog_flist = 1'b0; cap_park = 1'b0;
        chk("R10 irq output", {24'b0, irq_thresh}, 32'h20);
        chk("R9 flist output", {30'b0, flist_size}, 1);

        // R2 run from halted
        wr(8'h10, 32'h00200015);
        chk("R2 halted before drop", {31'b0, halted}, 1);
        @(negedge clk);
        chk("R2 halted dropped", {31'b0, halted}, 0);
        chk("R2 run_req", {31'b0, run_req}, 1);

        // R6 reset refused while running
        wr(8'h10, 32'h00200017);
        rd(8'h10, r); chk("R6 reset ignored", r, 32'h00200015);
        chk("R6 reset_req", {31'b0, reset_req}, 0);

        // stop, then R2 refused restart while stopping
        wr(8'h10, 32'h00200014);
        wr(8'h10, 32'h00200015);
        chk("R2 run refused", {31'b0, run_req}, 0);
        repeat (3) @(negedge clk);
        chk("R3 still stopping", {31'b0, halted}, 0);
        pulse(core_pipe_idle);
        chk("R3 idle halts", {31'b0, halted}, 1);

        // R4 tick deadline
        wr(8'h10, 32'h00200015);
        @(negedge clk);
        wr(8'h10, 32'h00200014);
        for (int k = 0; k < 15; k++) pulse(uframe_tick);
        chk("R4 halted after 15 ticks", {31'b0, halted}, 0);
        pulse(uframe_tick);
        chk("R4 halted after 16 ticks", {31'b0, halted}, 1);

        // R5 full reset
        wr(8'h10, 32'h00200016);
        rd(8'h10, r); chk("R5 reset set", r, 32'h00200016);
        wr(8'h10, 32'h00200014);
        rd(8'h10, r); chk("R5 write 0 ignored", r, 32'h00200016);
        chk("R5 reset_req held", {31'b0, reset_req}, 1);
        pulse(core_reset_done);
        rd(8'h10, r); chk("R5 restored", r, 32'h00080B00);

        // R7 doorbell
        wr(8'h10, 32'h00080B60);
        chk("R7 doorbell_req", {31'b0, doorbell_req}, 1);
        wr(8'h10, 32'h00080B20);
        rd(8'h10, r); chk("R7 write 0 ignored", r, 32'h00080B60);
        pulse(core_iaa_done);
        rd(8'h10, r); chk("R7 cleared by core", r, 32'h00080B20);

        // R8 light reset
        wr(8'h10, 32'h00080BA0);
        rd(8'h10, r); chk("R8 light set", r, 32'h00080BA0);
        wr(8'h10, 32'h00080B20);
        rd(8'h10, r); chk("R8 write 0 ignored", r, 32'h00080BA0);
        pulse(core_light_done);
        rd(8'h10, r); chk("R8 cleared by core", r, 32'h00080B20);

        finish_run();
    end

endmodule